// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, using only its 48-bit destination address. The six destination bytes arrive one per valid cycle, first byte first, with a start-of-frame marker on the first one. Cycles without the valid strobe are allowed between bytes. One cycle after the sixth byte is taken, the block raises a decision-valid flag together with an accept flag. Both stay fixed until the next start of frame.

The address is sorted into one of three classes: broadcast (all 48 bits set), multicast (bit 0 of the first byte set, not broadcast) or unicast (everything else). Each class has its own acceptance rule. An exact match against the station address can also accept a frame, whatever its class. A multicast frame may be accepted through a 64-bit hash table. The table is indexed by six bits of a CRC-32 that is computed on the fly, one byte per cycle, over the destination bytes only.

Top module: `rx_addr_filter`

## Requirements
- R1: Byte k of the address (k = 0 for the byte marked start-of-frame) lands in address bits 8k+7..8k. Only bytes with `byte_vld_i` high are counted. When the sixth counted byte is taken at a clock edge, `dec_valid_o` is high after that same edge.
- R2: The hash index is bits 28..23 of the bit-inverted CRC-32 over the six bytes. The CRC uses reflected polynomial 0xEDB88320, starts from all ones, and takes each byte least significant bit first. An index k below 32 selects bit k of `hash_lo_i`. A larger index selects bit k-32 of `hash_hi_i`.
- R3: An address with all 48 bits set is broadcast. Any other address with bit 0 of byte 0 set is multicast. Every other address is unicast.
- R4: A broadcast address is accepted when `bcast_en_i` is 1.
- R5: A multicast address is accepted when `mcast_all_en_i` is 1, or when `hash_en_i` is 1 and the selected table bit is 1.
- R6: A unicast address is accepted when `ucast_en_i` is 1.
- R7: With `exact_en_i` at 1, an address equal to {`station_hi_i`, `station_lo_i`} is accepted whatever its class. Byte 0 is compared with `station_lo_i[7:0]` and byte 5 with `station_hi_i[15:8]`. Nothing else leads to acceptance.
- R8: Once the decision is valid, `dec_valid_o` and `accept_o` hold steady until the next start-of-frame byte. Extra bytes and configuration changes in that interval have no effect on them.
- R9: Reset clears `dec_valid_o` and `accept_o`. A byte taken with `sof_i` high clears both after that edge and restarts address capture.
- R10: After reset, valid bytes are ignored until a byte arrives with `sof_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Marks the first destination byte; used only when byte_vld_i is high |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Destination address byte |
| station_lo_i | input | 32 | Station address bytes 0..3 (byte 0 in bits 7..0) |
| station_hi_i | input | 16 | Station address bytes 4..5 (byte 4 in bits 7..0) |
| hash_lo_i | input | 32 | Hash table entries 0..31 |
| hash_hi_i | input | 32 | Hash table entries 32..63 |
| ucast_en_i | input | 1 | Accept every unicast address |
| mcast_all_en_i | input | 1 | Accept every multicast address |
| bcast_en_i | input | 1 | Accept broadcast |
| hash_en_i | input | 1 | Accept multicast through the hash table |
| exact_en_i | input | 1 | Accept an exact station address match |
| dec_valid_o | output | 1 | Decision valid |
| accept_o | output | 1 | Frame accepted |

## Verification
The bench checks multicast hashing in both halves of the table. It uses single-bit and all-but-one tables at the exact index, so a wrong CRC bit order, seed, inversion, index slice or word select gives the wrong decision. It drives the all-ones address with broadcast enabled and disabled, and the station address with every class enable off, so a filter that misclassifies or ignores the exact-match path is caught. Trailing bytes, configuration changes after the decision, idle gaps between bytes, and bytes before the first start-of-frame are also driven. A design that keeps counting, re-decides or starts capturing without a marker shows up as a changed or early decision.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int DA_BYTES   = 6;
    localparam int DA_W       = DA_BYTES * 8;
    localparam int CRC_W      = 32;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_LSB   = 23;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED      = '1;

    typedef enum logic [1:0] {
        CLS_UNICAST   = 2'd0,
        CLS_MULTICAST = 2'd1,
        CLS_BROADCAST = 2'd2
    } da_class_e;

    typedef struct packed {
        logic ucast_en;
        logic mcast_all_en;
        logic bcast_en;
        logic hash_en;
        logic exact_en;
    } filt_cfg_t;

    // Advance a reflected CRC-32 by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                       input logic [7:0]       b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-8){1'b0}}, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    function automatic da_class_e classify(input logic [DA_W-1:0] a);
        if (&a)       return CLS_BROADCAST;
        else if (a[0]) return CLS_MULTICAST;
        else           return CLS_UNICAST;
    endfunction

endpackage

// File: rtl/rxaf_capture.sv
module rxaf_capture
    import rxaf_pkg::*;
#(
    parameter int NBYTES = DA_BYTES,
    localparam int AW    = NBYTES * 8,
    localparam int CNT_W = $clog2(NBYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic          vld,
    input  logic [7:0]    data,
    output logic          take,
    output logic          restart,
    output logic          last,
    output logic [AW-1:0] addr_next
);

    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] slot;

    always_comb begin
        restart   = vld && sof;
        take      = restart || (vld && (cnt_q < CNT_W'(NBYTES)));
        slot      = restart ? '0 : cnt_q;
        addr_next = restart ? '0 : addr_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (take && (slot == CNT_W'(i))) addr_next[i*8 +: 8] = data;
        end
        last = take && (slot == CNT_W'(NBYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_W'(NBYTES);
            addr_q <= '0;
        end else if (take) begin
            cnt_q  <= slot + 1'b1;
            addr_q <= addr_next;
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NBYTES));

endmodule

// File: rtl/rxaf_crc.sv
module rxaf_crc
    import rxaf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             take,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc_final_next
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    always_comb begin
        crc_next = crc_q;
        if (take) crc_next = crc_step_byte(restart ? CRC_SEED : crc_q, data);
        crc_final_next = ~crc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= CRC_SEED;
        else     crc_q <= crc_next;
    end

    // R2
    crc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(crc_q));

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
#(
    parameter int AW     = DA_W,
    parameter int IDX_W  = HASH_IDX_W,
    parameter int IDX_LO = HASH_LSB,
    localparam int TBL_HALF = (1 << IDX_W) / 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic                restart,
    input  logic [AW-1:0]       addr,
    input  logic [CRC_W-1:0]    crc_final,
    input  filt_cfg_t           cfg,
    input  logic [AW-1:0]       station,
    input  logic [TBL_HALF-1:0] tbl_lo,
    input  logic [TBL_HALF-1:0] tbl_hi,
    output logic                valid_o,
    output logic                accept_o
);

    da_class_e        cls;
    logic [IDX_W-1:0] idx;
    logic             tbl_bit;
    logic             exact_hit;
    logic             acc;

    always_comb begin
        cls       = classify(addr);
        idx       = crc_final[IDX_LO +: IDX_W];
        tbl_bit   = idx[IDX_W-1] ? tbl_hi[idx[IDX_W-2:0]] : tbl_lo[idx[IDX_W-2:0]];
        exact_hit = cfg.exact_en && (addr == station);
        unique case (cls)
            CLS_BROADCAST: acc = cfg.bcast_en;
            CLS_MULTICAST: acc = cfg.mcast_all_en || (cfg.hash_en && tbl_bit);
            default:       acc = cfg.ucast_en;
        endcase
        acc = acc || exact_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            accept_o <= 1'b0;
        end else if (fire) begin
            valid_o  <= 1'b1;
            accept_o <= acc;
        end else if (restart) begin
            valid_o  <= 1'b0;
            accept_o <= 1'b0;
        end
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !restart && !fire) |=> (valid_o && $stable(accept_o)));

    // R9
    restart_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (restart && !fire) |=> (!valid_o && !accept_o));

    // R9
    acc_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> valid_o);

    // R9
    reset_clr_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && !accept_o));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sof_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    input  logic [31:0] station_lo_i,
    input  logic [15:0] station_hi_i,
    input  logic [31:0] hash_lo_i,
    input  logic [31:0] hash_hi_i,
    input  logic        ucast_en_i,
    input  logic        mcast_all_en_i,
    input  logic        bcast_en_i,
    input  logic        hash_en_i,
    input  logic        exact_en_i,
    output logic        dec_valid_o,
    output logic        accept_o
);

    logic             take;
    logic             restart;
    logic             last;
    logic [DA_W-1:0]  addr_next;
    logic [CRC_W-1:0] crc_final_next;
    filt_cfg_t        cfg;

    assign cfg = '{ucast_en:     ucast_en_i,
                   mcast_all_en: mcast_all_en_i,
                   bcast_en:     bcast_en_i,
                   hash_en:      hash_en_i,
                   exact_en:     exact_en_i};

    rxaf_capture #(.NBYTES(DA_BYTES)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof_i),
        .vld       (byte_vld_i),
        .data      (byte_i),
        .take      (take),
        .restart   (restart),
        .last      (last),
        .addr_next (addr_next)
    );

    rxaf_crc u_crc (
        .clk            (clk),
        .rst            (rst),
        .restart        (restart),
        .take           (take),
        .data           (byte_i),
        .crc_final_next (crc_final_next)
    );

    rxaf_decide #(.AW(DA_W), .IDX_W(HASH_IDX_W), .IDX_LO(HASH_LSB)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .fire      (last),
        .restart   (restart),
        .addr      (addr_next),
        .crc_final (crc_final_next),
        .cfg       (cfg),
        .station   ({station_hi_i, station_lo_i}),
        .tbl_lo    (hash_lo_i),
        .tbl_hi    (hash_hi_i),
        .valid_o   (dec_valid_o),
        .accept_o  (accept_o)
    );

endmodule

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [31:0] station_lo_i = '0;
    logic [15:0] station_hi_i = '0;
    logic [31:0] hash_lo_i = '0;
    logic [31:0] hash_hi_i = '0;
    logic        ucast_en_i = 1'b0;
    logic        mcast_all_en_i = 1'b0;
    logic        bcast_en_i = 1'b0;
    logic        hash_en_i = 1'b0;
    logic        exact_en_i = 1'b0;
    logic        dec_valid_o;
    logic        accept_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    rx_addr_filter uut (.*);

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Bit-serial model of the hash index over 48 address bits.
    function automatic logic [5:0] model_idx(logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        logic fb;
        for (int i = 0; i < 48; i++) begin
            fb = c[0] ^ a[i];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
        end
        c = ~c;
        return c[28:23];
    endfunction

    function automatic logic model_accept(logic [47:0] a);
        logic bc, mc, uc, tb;
        logic [63:0] tbl;
        bc  = (a == 48'hFFFF_FFFF_FFFF);
        mc  = !bc && a[0];
        uc  = !bc && !mc;
        tbl = {hash_hi_i, hash_lo_i};
        tb  = tbl[model_idx(a)];
        return (bc && bcast_en_i) || (mc && (mcast_all_en_i || (hash_en_i && tb))) ||
               (uc && ucast_en_i) || (exact_en_i && (a == {station_hi_i, station_lo_i}));
    endfunction

    task automatic put_byte(logic [7:0] b, logic s);
        byte_vld_i = 1'b1; sof_i = s; byte_i = b;
        @(negedge clk);
        byte_vld_i = 1'b0; sof_i = 1'b0; byte_i = 8'($urandom);
    endtask

    // Sends an address; returns at the negedge after the sixth byte.
    task automatic send_addr(logic [47:0] a, bit gaps);
        for (int i = 0; i < 6; i++) begin
            if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
            put_byte(a[i*8 +: 8], i == 0);
            if (i == 0) chk("R9 sof clears valid", dec_valid_o, 1'b0);
        end
    endtask

    task automatic frame(string req, logic [47:0] a, bit gaps);
        logic exp;
        exp = model_accept(a);
        send_addr(a, gaps);
        chk({req, " valid"}, dec_valid_o, 1'b1);
        chk({req, " accept"}, accept_o, exp);
    endtask

    task automatic rand_cfg();
        {ucast_en_i, mcast_all_en_i, bcast_en_i, hash_en_i, exact_en_i} = 5'($urandom);
        hash_lo_i = $urandom; hash_hi_i = $urandom;
    endtask

    function automatic logic [47:0] mcast_with_half(bit hi);
        logic [47:0] a;
        do begin
            a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
            a[0] = 1'b1;
        end while ((model_idx(a) >= 32) != hi || (&a));
        return a;
    endfunction

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic [47:0] st, a, b;
        logic        held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 reset valid", dec_valid_o, 1'b0);
        chk("R9 reset accept", accept_o, 1'b0);

        // R10: bytes before any start-of-frame are ignored
        {ucast_en_i, mcast_all_en_i, bcast_en_i} = 3'b111;
        repeat (8) put_byte(8'hFF, 1'b0);
        chk("R10 no sof no decision", dec_valid_o, 1'b0);

        st = 48'h5A4B_3C2D_1E02;
        station_lo_i = st[31:0]; station_hi_i = st[47:32];

        // R4 broadcast
        {ucast_en_i, mcast_all_en_i, bcast_en_i, hash_en_i, exact_en_i} = 5'b00100;
        frame("R4 bcast on", 48'hFFFF_FFFF_FFFF, 0);
        bcast_en_i = 0; mcast_all_en_i = 1;
        frame("R3 R4 bcast off not mcast", 48'hFFFF_FFFF_FFFF, 0);
        chk("R3 bcast rejected", accept_o, 1'b0);

        // R7 exact match, all class enables off
        {ucast_en_i, mcast_all_en_i, bcast_en_i, hash_en_i, exact_en_i} = 5'b00001;
        frame("R7 exact", st, 1);
        chk("R7 exact accepted", accept_o, 1'b1);
        frame("R7 near miss", st ^ 48'h8000_0000_0000, 1);
        chk("R7 near miss rejected", accept_o, 1'b0);
        exact_en_i = 0;
        frame("R7 exact disabled", st, 0);

        // R6 unicast
        ucast_en_i = 1;
        frame("R6 ucast", 48'h1234_5678_9A00, 0);
        chk("R6 ucast accepted", accept_o, 1'b1);
        ucast_en_i = 0;

        // R2 R5 hash in both halves with single and inverted table bits
        hash_en_i = 1;
        for (int h = 0; h < 2; h++) begin
            logic [63:0] t;
            a = mcast_with_half(h[0]);
            t = 64'd1 << model_idx(a);
            {hash_hi_i, hash_lo_i} = t;
            frame("R2 R5 hash single bit", a, 1);
            chk("R2 hash hit", accept_o, 1'b1);
            {hash_hi_i, hash_lo_i} = ~t;
            frame("R2 R5 hash other bits", a, 1);
            chk("R2 hash miss", accept_o, 1'b0);
            hash_en_i = 0; mcast_all_en_i = 1;
            frame("R5 mcast all", a, 0);
            mcast_all_en_i = 0; hash_en_i = 1;
        end

        // R8: trailing bytes and config changes do not alter the decision
        {ucast_en_i, mcast_all_en_i, bcast_en_i, hash_en_i, exact_en_i} = 5'b00100;
        frame("R8 setup", 48'hFFFF_FFFF_FFFF, 0);
        held = accept_o;
        put_byte(8'h00, 1'b0); put_byte(8'h11, 1'b0);
        bcast_en_i = 0;
        @(negedge clk);
        chk("R8 hold valid", dec_valid_o, 1'b1);
        chk("R8 hold accept", accept_o, held);

        // R9: restart mid-address, then complete a fresh one
        b = 48'h0000_0000_00FF;
        put_byte(8'hFF, 1'b1); put_byte(8'hFF, 1'b0);
        {ucast_en_i, bcast_en_i} = 2'b01;
        frame("R9 R1 restart", 48'hFFFF_FFFF_FFFF, 0);
        chk("R9 restart final", accept_o, 1'b1);

        // R1 byte placement: wrong order would mismatch the station
        {ucast_en_i, mcast_all_en_i, bcast_en_i, hash_en_i, exact_en_i} = 5'b00001;
        st = 48'h0605_0403_0200;
        station_lo_i = st[31:0]; station_hi_i = st[47:32];
        frame("R1 byte order", st, 1);
        chk("R1 byte order accepted", accept_o, 1'b1);
        frame("R1 reversed order", 48'h0002_0304_0506, 0);
        chk("R1 reversed rejected", accept_o, 1'b0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int kind;
            rand_cfg();
            st = {$urandom, $urandom};
            station_lo_i = st[31:0]; station_hi_i = st[47:32];
            kind = $urandom_range(0, 4);
            case (kind)
                0: a = 48'hFFFF_FFFF_FFFF;
                1: a = st;
                2: a = {$urandom, $urandom} | 48'h1;
                3: a = {$urandom, $urandom} & ~48'h1;
                default: a = st ^ (48'h1 << $urandom_range(0, 47));
            endcase
            frame("R3 R4 R5 R6 R7 random", a, $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 7) == 0) begin
                put_byte(8'($urandom), 1'b0);
                chk("R8 random trailing", dec_valid_o, 1'b1);
            end
        end

        // R9 reset after a decision
        {ucast_en_i, bcast_en_i} = 2'b01;
        frame("R9 pre-reset", 48'hFFFF_FFFF_FFFF, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clears valid", dec_valid_o, 1'b0);
        chk("R9 reset clears accept", accept_o, 1'b0);

        report();
    end

endmodule